// File: doc/BRIEF.md
# Register Alias Table with Rename Storage

This block sits between instruction decode and the execution units of an out-of-order core. It holds a small architectural register file, a separate pool of rename slots, and one mapping entry per architectural register. When an instruction with a destination is renamed, the block takes a free rename slot and points that architectural register at it. Execution results are written into rename slots by tag. When the reorder buffer retires an instruction, the block copies the slot's value into architectural state and returns the slot to the free pool.

Each mapping entry holds a committed flag and a rename tag. Two combinational source-read ports use this entry to choose a source. A committed register returns its architectural value. An uncommitted register returns the contents of its mapped slot, and also reports whether that slot is valid, so a consumer can wait on the tag. A result written in the same cycle is forwarded to the readers.

Top module: `rat_rename_core`

## Requirements
- R1: After reset, every architectural register reads as committed and ready with value 0, and all 7 rename slots are free.
- R2: When a rename request is made and a slot is free, `ren_ok` is 1 and `ren_tag` gives the lowest-numbered free slot. From the next cycle that slot is no longer free, and the renamed register reads as not committed, mapped to that tag.
- R3: A read of a committed register returns its architectural value with ready set to 1.
- R4: A read of an uncommitted register whose mapped slot is valid returns the slot value with ready set to 1.
- R5: A read of an uncommitted register whose mapped slot is not valid returns ready 0, and the read tag equals the mapped slot number.
- R6: A result write to the slot that a read is mapped to, in the same cycle, returns the written value with ready set to 1.
- R7: A commit copies the stored value of slot `cm_tag` into architectural register `cm_arch`. The register becomes committed again only if its mapping still names `cm_tag`. Otherwise it stays mapped to the younger slot.
- R8: A commit returns its slot to the free pool. That slot cannot be allocated in the same cycle as the commit, but it can be allocated from the next cycle on.
- R9: When no slot is free, a rename request gets `ren_ok` = 0 and changes neither the mapping nor the free pool.
- R10: When a rename and a commit target the same architectural register in the same cycle, the rename decides the mapping (uncommitted, new tag). The architectural value is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_req | input | 1 | Rename request for a destination |
| ren_arch | input | 2 | Destination architectural register |
| ren_ok | output | 1 | Rename accepted this cycle |
| ren_tag | output | 3 | Slot allocated (lowest free) |
| wb_en | input | 1 | Result write enable |
| wb_tag | input | 3 | Slot receiving the result |
| wb_data | input | 16 | Result value |
| cm_en | input | 1 | Commit from the reorder buffer |
| cm_arch | input | 2 | Architectural register being committed |
| cm_tag | input | 3 | Slot being committed |
| rd0_arch | input | 2 | Read port 0 register select |
| rd0_value | output | 16 | Read port 0 value |
| rd0_ready | output | 1 | Read port 0 value is usable |
| rd0_tag | output | 3 | Read port 0 mapped slot |
| rd1_arch | input | 2 | Read port 1 register select |
| rd1_value | output | 16 | Read port 1 value |
| rd1_ready | output | 1 | Read port 1 value is usable |
| rd1_tag | output | 3 | Read port 1 mapped slot |

## Verification
Two cases need care because rename and commit can both act on one architectural register in the same cycle. The first is a commit of an older tag while a rename of the same register is in flight. The second is a slot being freed while a new one is allocated. The bench creates both cases deliberately. It then reads the register on the next cycle and expects the new uncommitted mapping, and it expects the freed slot to be skipped by that cycle's allocation but handed out on the next rename. A behavioural model then drives random mixes of rename, result write and commit, and every port output is compared against it on every cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;
    parameter int NUM_ARCH = 4;
    parameter int NUM_REN  = 7;
    parameter int DATA_W   = 16;
    parameter int NUM_RD   = 2;

    localparam int AW = $clog2(NUM_ARCH);
    localparam int TW = $clog2(NUM_REN);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TW-1:0]     tag_t;
    typedef logic [AW-1:0]     areg_t;

    typedef struct packed {
        logic committed;
        tag_t tag;
    } map_ent_t;

    typedef struct packed {
        logic  valid;
        word_t value;
    } slot_t;

    typedef struct packed {
        word_t value;
        logic  ready;
        tag_t  tag;
    } rd_rsp_t;

    function automatic logic tag_in_range(tag_t t);
        return int'(t) < NUM_REN;
    endfunction
endpackage

// File: rtl/rat_free_list.sv
module rat_free_list
    import rat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_req,
    output logic               alloc_ok,
    output tag_t               alloc_tag,
    input  logic               rel_en,
    input  tag_t               rel_tag,
    output logic [NUM_REN-1:0] free_vec
);
    logic               any_free;
    logic [NUM_REN-1:0] free_nxt;

    // lowest-numbered free slot wins
    always_comb begin
        alloc_tag = '0;
        any_free  = 1'b0;
        for (int i = NUM_REN - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                alloc_tag = tag_t'(i);
                any_free  = 1'b1;
            end
        end
        alloc_ok = alloc_req && any_free;
    end

    // release first, then allocation; allocation uses the pre-release view
    always_comb begin
        free_nxt = free_vec;
        for (int i = 0; i < NUM_REN; i++) begin
            if (rel_en && int'(rel_tag) == i)
                free_nxt[i] = 1'b1;
            if (alloc_ok && int'(alloc_tag) == i)
                free_nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) free_vec <= '1;
        else     free_vec <= free_nxt;
    end
endmodule

// File: rtl/rat_slot_file.sv
module rat_slot_file
    import rat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_en,
    input  tag_t  alloc_tag,
    input  logic  wb_en,
    input  tag_t  wb_tag,
    input  word_t wb_data,
    output slot_t slots [NUM_REN]
);
    for (genvar s = 0; s < NUM_REN; s++) begin : g_slot
        logic hit_alloc, hit_wb;
        assign hit_alloc = alloc_en && int'(alloc_tag) == s;
        assign hit_wb    = wb_en && int'(wb_tag) == s;

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[s] <= '0;
            end else if (hit_alloc) begin
                slots[s].valid <= 1'b0;
            end else if (hit_wb) begin
                slots[s].valid <= 1'b1;
                slots[s].value <= wb_data;
            end
        end
    end
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ren_en,
    input  areg_t    ren_arch,
    input  tag_t     ren_tag,
    input  logic     cm_en,
    input  areg_t    cm_arch,
    input  tag_t     cm_tag,
    input  word_t    cm_value,
    output map_ent_t map [NUM_ARCH],
    output word_t    arch_val [NUM_ARCH]
);
    for (genvar a = 0; a < NUM_ARCH; a++) begin : g_arch
        logic ren_hit, cm_hit;
        assign ren_hit = ren_en && int'(ren_arch) == a;
        assign cm_hit  = cm_en && int'(cm_arch) == a;

        always_ff @(posedge clk) begin
            if (rst) begin
                map[a]      <= '{committed: 1'b1, tag: '0};
                arch_val[a] <= '0;
            end else begin
                if (cm_hit)
                    arch_val[a] <= cm_value;
                if (ren_hit) begin
                    map[a].committed <= 1'b0;
                    map[a].tag       <= ren_tag;
                end else if (cm_hit && !map[a].committed && map[a].tag == cm_tag) begin
                    map[a].committed <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rat_read_port.sv
module rat_read_port
    import rat_pkg::*;
(
    input  map_ent_t ent,
    input  word_t    aval,
    input  slot_t    slots [NUM_REN],
    input  logic     wb_en,
    input  tag_t     wb_tag,
    input  word_t    wb_data,
    output rd_rsp_t  rsp
);
    slot_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REN; i++)
            if (int'(ent.tag) == i) sel = slots[i];
    end

    always_comb begin
        rsp.tag = ent.tag;
        if (ent.committed) begin
            rsp.value = aval;
            rsp.ready = 1'b1;
        end else if (wb_en && wb_tag == ent.tag) begin
            rsp.value = wb_data;
            rsp.ready = 1'b1;
        end else if (tag_in_range(ent.tag)) begin
            rsp.value = sel.value;
            rsp.ready = sel.valid;
        end else begin
            rsp.value = '0;
            rsp.ready = 1'b0;
        end
    end
endmodule

// File: rtl/rat_rename_core.sv
module rat_rename_core
    import rat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ren_req,
    input  logic [1:0]  ren_arch,
    output logic        ren_ok,
    output logic [2:0]  ren_tag,
    input  logic        wb_en,
    input  logic [2:0]  wb_tag,
    input  logic [15:0] wb_data,
    input  logic        cm_en,
    input  logic [1:0]  cm_arch,
    input  logic [2:0]  cm_tag,
    input  logic [1:0]  rd0_arch,
    output logic [15:0] rd0_value,
    output logic        rd0_ready,
    output logic [2:0]  rd0_tag,
    input  logic [1:0]  rd1_arch,
    output logic [15:0] rd1_value,
    output logic        rd1_ready,
    output logic [2:0]  rd1_tag
);
    logic [NUM_REN-1:0] free_vec;
    tag_t               alloc_tag;
    logic               alloc_ok;
    slot_t              slots [NUM_REN];
    map_ent_t           map [NUM_ARCH];
    word_t              arch_val [NUM_ARCH];
    word_t              cm_value;
    logic               cm_ok;
    areg_t              rd_sel [NUM_RD];
    rd_rsp_t            rd_rsp [NUM_RD];

    assign cm_ok = cm_en && tag_in_range(cm_tag);

    rat_free_list u_free (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (ren_req),
        .alloc_ok  (alloc_ok),
        .alloc_tag (alloc_tag),
        .rel_en    (cm_ok),
        .rel_tag   (cm_tag),
        .free_vec  (free_vec)
    );

    rat_slot_file u_slots (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_ok),
        .alloc_tag (alloc_tag),
        .wb_en     (wb_en),
        .wb_tag    (wb_tag),
        .wb_data   (wb_data),
        .slots     (slots)
    );

    // commit copies the stored slot value (not the same-cycle result)
    always_comb begin
        cm_value = '0;
        for (int i = 0; i < NUM_REN; i++)
            if (int'(cm_tag) == i) cm_value = slots[i].value;
    end

    rat_map_table u_map (
        .clk      (clk),
        .rst      (rst),
        .ren_en   (alloc_ok),
        .ren_arch (ren_arch),
        .ren_tag  (alloc_tag),
        .cm_en    (cm_ok),
        .cm_arch  (cm_arch),
        .cm_tag   (cm_tag),
        .cm_value (cm_value),
        .map      (map),
        .arch_val (arch_val)
    );

    assign rd_sel[0] = rd0_arch;
    assign rd_sel[1] = rd1_arch;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        map_ent_t ent;
        word_t    aval;
        always_comb begin
            ent  = '0;
            aval = '0;
            for (int a = 0; a < NUM_ARCH; a++) begin
                if (int'(rd_sel[p]) == a) begin
                    ent  = map[a];
                    aval = arch_val[a];
                end
            end
        end

        rat_read_port u_rd (
            .ent     (ent),
            .aval    (aval),
            .slots   (slots),
            .wb_en   (wb_en),
            .wb_tag  (wb_tag),
            .wb_data (wb_data),
            .rsp     (rd_rsp[p])
        );
    end

    assign ren_ok    = alloc_ok;
    assign ren_tag   = alloc_tag;
    assign rd0_value = rd_rsp[0].value;
    assign rd0_ready = rd_rsp[0].ready;
    assign rd0_tag   = rd_rsp[0].tag;
    assign rd1_value = rd_rsp[1].value;
    assign rd1_ready = rd_rsp[1].ready;
    assign rd1_tag   = rd_rsp[1].tag;
endmodule

// File: rtl/rat_core_chk.sv
module rat_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       ren_req,
    input logic       ren_ok,
    input logic [2:0] ren_tag,
    input logic       cm_en,
    input logic [2:0] cm_tag,
    input logic [6:0] free_vec
);
    // R9
    stall_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_req && free_vec == '0) |-> !ren_ok);

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        ren_ok |-> ren_req);

    // R2
    grant_was_free_chk: assert property (@(posedge clk) disable iff (rst)
        ren_ok |-> free_vec[ren_tag]);

    // R2
    grant_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_ok && !(cm_en && cm_tag == ren_tag)) |=> !free_vec[$past(ren_tag)]);

    // R8
    release_free_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_en && cm_tag < 3'd7 && !(ren_ok && ren_tag == cm_tag)) |=> free_vec[$past(cm_tag)]);
endmodule

bind rat_rename_core rat_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ren_req  (ren_req),
    .ren_ok   (ren_ok),
    .ren_tag  (ren_tag),
    .cm_en    (cm_en),
    .cm_tag   (cm_tag),
    .free_vec (free_vec)
);

// File: tb/tb_rat_rename_core.sv
module tb_rat_rename_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        ren_req;
    logic [1:0]  ren_arch;
    logic        ren_ok;
    logic [2:0]  ren_tag;
    logic        wb_en;
    logic [2:0]  wb_tag;
    logic [15:0] wb_data;
    logic        cm_en;
    logic [1:0]  cm_arch;
    logic [2:0]  cm_tag;
    logic [1:0]  rd0_arch, rd1_arch;
    logic [15:0] rd0_value, rd1_value;
    logic        rd0_ready, rd1_ready;
    logic [2:0]  rd0_tag, rd1_tag;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference model state
    bit          m_com   [4];
    int          m_tag   [4];
    logic [15:0] m_av    [4];
    bit          m_rv    [7];
    logic [15:0] m_rval  [7];
    bit          m_free  [7];
    int          m_owner [7];

    always #10 clk = ~clk;

    rat_rename_core dut (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_lowest();
        for (int i = 0; i < 7; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    task automatic cmp_read(logic [1:0] a, logic [15:0] v, logic r, logic [2:0] t);
        string req;
        logic  er;
        logic [15:0] ev;
        if (m_com[a]) begin
            req = "R3"; er = 1; ev = m_av[a];
        end else if (wb_en && int'(wb_tag) == m_tag[a]) begin
            req = "R6"; er = 1; ev = wb_data;
        end else if (m_rv[m_tag[a]]) begin
            req = "R4"; er = 1; ev = m_rval[m_tag[a]];
        end else begin
            req = "R5"; er = 0; ev = 'x;
        end
        chk(req, "ready", 32'(r), 32'(er));
        chk(req, "tag", 32'(t), 32'(m_tag[a]));
        if (er) chk(req, "value", 32'(v), 32'(ev));
    endtask

    task automatic step();
        int  a;
        bit  ok;
        logic [15:0] cv;
        #1;
        a  = m_lowest();
        ok = ren_req && a >= 0;
        chk(a < 0 ? "R9" : "R2", "ren_ok", 32'(ren_ok), 32'(ok));
        if (ok) chk("R2", "ren_tag", 32'(ren_tag), 32'(a));
        cmp_read(rd0_arch, rd0_value, rd0_ready, rd0_tag);
        cmp_read(rd1_arch, rd1_value, rd1_ready, rd1_tag);
        if (cm_en) begin
            cv = m_rval[cm_tag];
            m_av[cm_arch] = cv;
            if (!m_com[cm_arch] && m_tag[cm_arch] == int'(cm_tag)) m_com[cm_arch] = 1;
            m_free[cm_tag] = 1;
        end
        if (wb_en && !(ok && a == int'(wb_tag))) begin
            m_rval[wb_tag] = wb_data;
            m_rv[wb_tag]   = 1;
        end
        if (ok) begin
            m_com[ren_arch] = 0;
            m_tag[ren_arch] = a;
            m_rv[a]         = 0;
            m_free[a]       = 0;
            m_owner[a]      = ren_arch;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ren_req = 0; ren_arch = 0; wb_en = 0; wb_tag = 0; wb_data = 0;
        cm_en = 0; cm_arch = 0; cm_tag = 0; rd0_arch = 0; rd1_arch = 0;
    endtask

    task automatic rename(logic [1:0] a);
        idle(); ren_req = 1; ren_arch = a; rd0_arch = a; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < 4; i++) begin m_com[i] = 1; m_tag[i] = 0; m_av[i] = 0; end
        for (int i = 0; i < 7; i++) begin m_rv[i] = 0; m_rval[i] = 0; m_free[i] = 1; m_owner[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        idle(); rd0_arch = 2; rd1_arch = 3; ren_req = 1;
        #1;
        chk("R1", "rd0_ready", 32'(rd0_ready), 1);
        chk("R1", "rd0_value", 32'(rd0_value), 0);
        chk("R1", "ren_tag", 32'(ren_tag), 0);
        step();
        rename(1); rename(2); rename(3);

        // R5 pending slot
        idle(); rd0_arch = 1;
        #1;
        chk("R5", "rd0_ready", 32'(rd0_ready), 0);
        chk("R5", "rd0_tag", 32'(rd0_tag), 1);
        step();

        // R6 same-cycle result
        idle(); wb_en = 1; wb_tag = 1; wb_data = 16'h1111; rd0_arch = 1;
        #1;
        chk("R6", "rd0_ready", 32'(rd0_ready), 1);
        chk("R6", "rd0_value", 32'(rd0_value), 32'h1111);
        step();

        idle(); rd0_arch = 1;
        #1;
        chk("R4", "rd0_value", 32'(rd0_value), 32'h1111);
        step();

        // R8 R10 commit and rename of r1 together
        idle(); cm_en = 1; cm_arch = 1; cm_tag = 1; ren_req = 1; ren_arch = 1;
        #1;
        chk("R8", "ren_tag", 32'(ren_tag), 4);
        step();
        idle(); rd0_arch = 1;
        #1;
        chk("R10", "rd0_ready", 32'(rd0_ready), 0);
        chk("R10", "rd0_tag", 32'(rd0_tag), 4);
        step();

        idle(); ren_req = 1; ren_arch = 0;
        #1;
        chk("R8", "ren_tag", 32'(ren_tag), 1);
        step();

        // R7 commit of an older tag keeps the younger mapping
        idle(); wb_en = 1; wb_tag = 0; wb_data = 16'h00AA; step();
        idle(); cm_en = 1; cm_arch = 0; cm_tag = 0; step();
        idle(); rd0_arch = 0;
        #1;
        chk("R7", "rd0_ready", 32'(rd0_ready), 0);
        chk("R7", "rd0_tag", 32'(rd0_tag), 1);
        step();

        // R9 exhaust the pool
        rename(2); rename(2); rename(2);
        idle(); ren_req = 1; ren_arch = 2; rd0_arch = 2;
        #1;
        chk("R9", "ren_ok", 32'(ren_ok), 0);
        step();
        idle(); rd0_arch = 2;
        #1;
        chk("R9", "rd0_tag", 32'(rd0_tag), 6);
        step();

        idle(); wb_en = 1; wb_tag = 6; wb_data = 16'h6666; step();
        idle(); cm_en = 1; cm_arch = 2; cm_tag = 6; step();
        idle(); rd0_arch = 2;
        #1;
        chk("R7", "rd0_ready", 32'(rd0_ready), 1);
        chk("R3", "rd0_value", 32'(rd0_value), 32'h6666);
        step();

        // random mixes against the model
        for (int n = 0; n < 500; n++) begin
            int s;
            idle();
            ren_req  = 1'($urandom);
            ren_arch = 2'($urandom);
            rd0_arch = 2'($urandom);
            rd1_arch = 2'($urandom);
            s = int'($urandom % 7);
            if (!m_free[s] && $urandom % 2 == 0) begin
                wb_en = 1; wb_tag = 3'(s); wb_data = 16'($urandom);
            end
            s = int'($urandom % 7);
            if (!m_free[s] && m_rv[s] && $urandom % 3 != 0) begin
                cm_en = 1; cm_tag = 3'(s); cm_arch = 2'(m_owner[s]);
            end
            step();
        end

        finish_run();
    end
endmodule